// File: doc/BRIEF.md
# Operand Barrel Shifter

A purely combinational 32-bit shifter that conditions the second operand of a data-processing operation before it reaches the arithmetic unit. It takes a data word, a shift kind, a shift distance and the current carry flag. It returns the shifted word and the shifter carry-out that a flag-setting operation may copy into its carry flag.

The distance comes from one of two sources. One is a 5-bit constant carried in the operation. The other is the low byte of a register, which may hold any value from 0 to 255. A select input chooses between them. Reading the register file, decoding the operation word and the arithmetic unit itself lie outside this block.

Top module: `operand_shifter`

## Requirements
- R1: Kind code 0 (shift left) and kind code 5 (arithmetic shift left) give the same result. For a distance n from 1 to 31, the result is value<<n and carry-out is value[32-n]. At n=32 the result is 0 and carry-out is value[0]. Above 32 both the result and carry-out are 0.
- R2: Kind code 1 (logical shift right): for n from 1 to 31 the result is value>>n with zero fill and carry-out is value[n-1]. At n=32 the result is 0 and carry-out is value[31]. Above 32 both are 0.
- R3: Kind code 2 (arithmetic shift right) fills vacated bits with value[31]. For n from 1 to 31, carry-out is value[n-1]. For n of 32 or more, every result bit and the carry-out equal value[31].
- R4: Kind code 3 (rotate right) rotates by n mod 32. If n mod 32 is nonzero, carry-out is result[31]. If n is a nonzero multiple of 32, the result equals value and carry-out is value[31].
- R5: Kind code 4 (extended rotate) ignores the distance and both distance sources. The result is {carry_i, value[31:1]} and carry-out is value[0].
- R6: When use_reg_i is 1, the distance is amt_reg_i, read as an unsigned 8-bit number. When it is 0, the distance is amt_imm_i, read as an unsigned 5-bit number. The source that is not selected has no effect.
- R7: For kind codes 0 to 3 and 5, a distance of zero from either source passes value unchanged, and carry-out equals carry_i.
- R8: Kind codes 6 and 7 are reserved. They pass value unchanged with carry-out equal to carry_i, whatever the distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value_i | input | 32 | Operand to be shifted |
| kind_i | input | 3 | Shift kind code (see R1 to R8) |
| use_reg_i | input | 1 | 1: distance from amt_reg_i, 0: from amt_imm_i |
| amt_imm_i | input | 5 | Constant shift distance |
| amt_reg_i | input | 8 | Register-supplied shift distance (low byte) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Some properties hold on every evaluation, and the assertions check those. A zero distance passes the operand through. The extended rotate places carry_i on top and value[0] on carry-out. Arithmetic right shifts keep the sign bit. Rotates keep the population count. Logical right shifts of 32 or more give zero. The selected distance is clamped to at most 33 before the shift network. Exact values need the bench's scenarios: the carry bit taken at each distance, the boundary at exactly 32 compared with distances beyond it, rotate distances taken modulo 32, the source that was not selected having no effect, and the reserved codes.

// File: rtl/operand_shifter_pkg.sv
package operand_shifter_pkg;
  typedef enum logic [2:0] {
    K_LSL  = 3'd0,
    K_LSR  = 3'd1,
    K_ASR  = 3'd2,
    K_ROR  = 3'd3,
    K_RRX  = 3'd4,
    K_ASL  = 3'd5,
    K_RSV6 = 3'd6,
    K_RSV7 = 3'd7
  } shift_kind_e;

  function automatic logic [31:0] bit_rev32(input logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = d[31-i];
    return r;
  endfunction
endpackage

// File: rtl/shift_amount_sel.sv
module shift_amount_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int REG_W  = 8,
  localparam int SH_W  = $clog2(DATA_W) + 1,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic             use_reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [REG_W-1:0] reg_i,
  output logic [SH_W-1:0]  amt_clamp_o,
  output logic [ROT_W-1:0] amt_mod_o,
  output logic             amt_zero_o,
  output logic             amt_ge_w_o
);
  logic [REG_W-1:0] amt_sel;

  always_comb begin
    amt_sel     = use_reg_i ? reg_i : REG_W'(imm_i);
    amt_zero_o  = (amt_sel == '0);
    amt_ge_w_o  = (amt_sel >= REG_W'(DATA_W));
    // anything past DATA_W behaves like DATA_W+1: all fill, fill carry
    amt_clamp_o = (amt_sel > REG_W'(DATA_W)) ? SH_W'(DATA_W + 1) : amt_sel[SH_W-1:0];
    amt_mod_o   = amt_sel[ROT_W-1:0];
  end

  always_comb begin
    assert_clamp_range_R6: assert (amt_clamp_o <= SH_W'(DATA_W + 1))
      else $error("clamped amount out of range");
  end
endmodule

// File: rtl/shift_funnel.sv
// Right shifter on {data, guard}; guard bit ends up holding last bit out.
module shift_funnel #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W) + 1,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              fill_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [DATA_W-1:0] data_o,
  output logic              out_bit_o
);
  logic [EXT_W-1:0] stage [SH_W+1];

  assign stage[0] = {data_i, 1'b0};

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{STEP{fill_i}}, stage[s][EXT_W-1:STEP]} : stage[s];
  end

  assign data_o    = stage[SH_W][EXT_W-1:1];
  assign out_bit_o = stage[SH_W][0];
endmodule

// File: rtl/shift_rotator.sv
module shift_rotator #(
  parameter int DATA_W = 32,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [ROT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] stage [ROT_W+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < ROT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][STEP-1:0], stage[s][DATA_W-1:STEP]} : stage[s];
  end

  assign data_o = stage[ROT_W];

  always_comb begin
    assert_rot_popcount_R4: assert ($countones(data_o) == $countones(data_i))
      else $error("rotate changed population count");
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import operand_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int REG_W  = 8,
  localparam int SH_W  = $clog2(DATA_W) + 1,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [2:0]        kind_i,
  input  logic              use_reg_i,
  input  logic [IMM_W-1:0]  amt_imm_i,
  input  logic [REG_W-1:0]  amt_reg_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  shift_kind_e      kind;
  logic [SH_W-1:0]  amt_clamp;
  logic [ROT_W-1:0] amt_mod;
  logic             amt_zero, amt_ge_w;
  logic [DATA_W-1:0] fun_in, fun_out, rot_out;
  logic [SH_W-1:0]  fun_amt;
  logic             fun_fill, fun_bit;
  logic             is_left;

  assign kind = shift_kind_e'(kind_i);

  shift_amount_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_W(REG_W)) u_amt (
    .use_reg_i  (use_reg_i),
    .imm_i      (amt_imm_i),
    .reg_i      (amt_reg_i),
    .amt_clamp_o(amt_clamp),
    .amt_mod_o  (amt_mod),
    .amt_zero_o (amt_zero),
    .amt_ge_w_o (amt_ge_w)
  );

  // left shifts reuse the right funnel on a bit-reversed word
  always_comb begin
    is_left  = (kind == K_LSL) || (kind == K_ASL);
    fun_in   = is_left ? bit_rev32(value_i) : value_i;
    fun_amt  = (kind == K_RRX) ? SH_W'(1) : amt_clamp;
    unique case (kind)
      K_ASR:   fun_fill = value_i[DATA_W-1];
      K_RRX:   fun_fill = carry_i;
      default: fun_fill = 1'b0;
    endcase
  end

  shift_funnel #(.DATA_W(DATA_W)) u_funnel (
    .data_i   (fun_in),
    .fill_i   (fun_fill),
    .amt_i    (fun_amt),
    .data_o   (fun_out),
    .out_bit_o(fun_bit)
  );

  shift_rotator #(.DATA_W(DATA_W)) u_rot (
    .data_i(value_i),
    .amt_i (amt_mod),
    .data_o(rot_out)
  );

  always_comb begin
    result_o = value_i;
    carry_o  = carry_i;
    unique case (kind)
      K_LSL, K_ASL: if (!amt_zero) begin
        result_o = bit_rev32(fun_out);
        carry_o  = fun_bit;
      end
      K_LSR, K_ASR: if (!amt_zero) begin
        result_o = fun_out;
        carry_o  = fun_bit;
      end
      K_ROR: if (!amt_zero) begin
        result_o = rot_out;
        carry_o  = rot_out[DATA_W-1];
      end
      K_RRX: begin
        result_o = fun_out;
        carry_o  = fun_bit;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (kind == K_RRX) begin
      assert_rrx_shape_R5: assert (result_o[DATA_W-1] == carry_i &&
                                   result_o[DATA_W-2:0] == value_i[DATA_W-1:1] &&
                                   carry_o == value_i[0])
        else $error("extended rotate shape wrong");
    end
    if (amt_zero && kind != K_RRX) begin
      assert_zero_pass_R7: assert (result_o == value_i && carry_o == carry_i)
        else $error("zero distance altered operand");
    end
    if (kind == K_ASR) begin
      assert_sign_keep_R3: assert (result_o[DATA_W-1] == value_i[DATA_W-1])
        else $error("arithmetic shift lost sign");
    end
    if (kind == K_LSR && amt_ge_w) begin
      assert_lsr_wide_zero_R2: assert (result_o == '0)
        else $error("wide logical right shift not zero");
    end
  end
endmodule

// File: tb/operand_shifter_test.sv
module operand_shifter_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] value_i, result_o;
  logic [2:0]  kind_i;
  logic        use_reg_i, carry_i, carry_o;
  logic [4:0]  amt_imm_i;
  logic [7:0]  amt_reg_i;

  operand_shifter uut (
    .value_i(value_i), .kind_i(kind_i), .use_reg_i(use_reg_i),
    .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // {use_reg, kind, imm, reg, cin, value, exp_result, exp_carry}
  localparam int NV = 26;
  localparam logic [82:0] VEC [NV] = '{
    {1'b0, 3'd0, 5'd4,  8'd0,   1'b0, 32'hF0F01234, 32'h0F012340, 1'b1}, // R1
    {1'b0, 3'd5, 5'd4,  8'd0,   1'b0, 32'hF0F01234, 32'h0F012340, 1'b1}, // R1 asl alias
    {1'b0, 3'd0, 5'd31, 8'd0,   1'b0, 32'h00000003, 32'h80000000, 1'b1}, // R1
    {1'b1, 3'd0, 5'd0,  8'd32,  1'b0, 32'h00000001, 32'h00000000, 1'b1}, // R1 n=32
    {1'b1, 3'd0, 5'd0,  8'd33,  1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R1 n>32
    {1'b0, 3'd1, 5'd8,  8'd0,   1'b1, 32'hF0F01234, 32'h00F0F012, 1'b0}, // R2
    {1'b0, 3'd1, 5'd1,  8'd0,   1'b0, 32'h00000003, 32'h00000001, 1'b1}, // R2
    {1'b1, 3'd1, 5'd0,  8'd32,  1'b0, 32'h80000000, 32'h00000000, 1'b1}, // R2 n=32
    {1'b1, 3'd1, 5'd0,  8'd200, 1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R2 n>32
    {1'b0, 3'd2, 5'd4,  8'd0,   1'b1, 32'hF0F01234, 32'hFF0F0123, 1'b0}, // R3
    {1'b1, 3'd2, 5'd0,  8'd40,  1'b0, 32'h80000000, 32'hFFFFFFFF, 1'b1}, // R3 wide
    {1'b1, 3'd2, 5'd0,  8'd32,  1'b1, 32'h7FFFFFFF, 32'h00000000, 1'b0}, // R3 n=32
    {1'b0, 3'd3, 5'd8,  8'd0,   1'b1, 32'hF0F01234, 32'h34F0F012, 1'b0}, // R4
    {1'b1, 3'd3, 5'd0,  8'd32,  1'b0, 32'h80000001, 32'h80000001, 1'b1}, // R4 mult 32
    {1'b1, 3'd3, 5'd0,  8'd64,  1'b1, 32'h00000001, 32'h00000001, 1'b0}, // R4 mult 32
    {1'b1, 3'd3, 5'd0,  8'd36,  1'b1, 32'hF0F01234, 32'h4F0F0123, 1'b0}, // R4 mod
    {1'b0, 3'd4, 5'd0,  8'd0,   1'b1, 32'hF0F01234, 32'hF878091A, 1'b0}, // R5
    {1'b0, 3'd4, 5'd9,  8'd0,   1'b0, 32'h00000003, 32'h00000001, 1'b1}, // R5
    {1'b1, 3'd4, 5'd0,  8'd5,   1'b0, 32'h00000002, 32'h00000001, 1'b0}, // R5 ignores amt
    {1'b0, 3'd1, 5'd1,  8'd31,  1'b0, 32'h80000000, 32'h40000000, 1'b0}, // R6 imm used
    {1'b1, 3'd1, 5'd1,  8'd4,   1'b0, 32'h80000000, 32'h08000000, 1'b0}, // R6 reg used
    {1'b0, 3'd0, 5'd0,  8'd7,   1'b1, 32'h12345678, 32'h12345678, 1'b1}, // R6/R7
    {1'b1, 3'd0, 5'd9,  8'd0,   1'b1, 32'h12345678, 32'h12345678, 1'b1}, // R7
    {1'b1, 3'd3, 5'd0,  8'd0,   1'b0, 32'h80000000, 32'h80000000, 1'b0}, // R7
    {1'b0, 3'd6, 5'd4,  8'd0,   1'b1, 32'hABCD0000, 32'hABCD0000, 1'b1}, // R8
    {1'b1, 3'd7, 5'd0,  8'd200, 1'b0, 32'hABCD0000, 32'hABCD0000, 1'b0}  // R8
  };

  task automatic apply(input logic ur, input logic [2:0] k, input logic [4:0] im,
                       input logic [7:0] rg, input logic ci, input logic [31:0] v);
    @(negedge clk);
    use_reg_i = ur; kind_i = k; amt_imm_i = im; amt_reg_i = rg; carry_i = ci; value_i = v;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic ec);
    n_checks++;
    if (result_o !== er || carry_o !== ec) begin
      n_fail++;
      $display("FAIL %s: got %h/%b expected %h/%b", req, result_o, carry_o, er, ec);
    end
  endtask

  initial begin
    value_i = '0; kind_i = '0; use_reg_i = 1'b0; amt_imm_i = '0; amt_reg_i = '0; carry_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    check("R7 idle", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][82], VEC[i][81:79], VEC[i][78:74], VEC[i][73:66], VEC[i][65], VEC[i][64:33]);
      check($sformatf("vec %0d", i), VEC[i][32:1], VEC[i][0]);
    end

    // R2 sweep: all-ones, carry always 1
    for (int n = 1; n < 32; n++) begin
      apply(1'b1, 3'd1, 5'd0, 8'(n), 1'b0, 32'hFFFFFFFF);
      check("R2 sweep", 32'hFFFFFFFF >> n, 1'b1);
    end
    // R1 sweep: single bit at position 0, carry 0 until n=32
    for (int n = 1; n < 33; n++) begin
      apply(1'b1, 3'd0, 5'd0, 8'(n), 1'b1, 32'h00000001);
      check("R1 sweep", (n < 32) ? (32'h1 << n) : 32'h0, (n == 32));
    end
    // R4 sweep: distances n and n+32 agree
    for (int n = 1; n < 32; n++) begin
      logic [31:0] exp_r;
      exp_r = (32'hC0000005 >> n) | (32'hC0000005 << (32 - n));
      apply(1'b1, 3'd3, 5'd0, 8'(n + 32), 1'b0, 32'hC0000005);
      check("R4 sweep", exp_r, exp_r[31]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule